// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block places one test cell between each core output and its device pin. The cells are joined into a single serial shift path. Bits enter at a serial input and leave from the cell farthest from it. Each cell has two storage stages. The first is a capture/shift stage, which can take a parallel snapshot of the pin value or pass bits along the chain. The second is an update latch, which copies the shift stage only when an update strobe arrives. Because of this, the pins do not ripple while a new pattern is being shifted in.

An external test access controller drives the strobes and the mode controls. In normal operation the core drives the pins through one multiplexer level, and no clock is involved. Sampling and preloading work while the core keeps control of the pins. When the drive-from-latch mode is selected, the pins take the preloaded latch values and all pin drivers are enabled. This covers both the external interconnect test and the clamp isolation, which differ only in which register the controller puts on the scan path. A separate isolation control disables every pin driver and overrides all other modes.

Top module: `bscan_chain`

## Requirements
- R1: While reset is low, all shift stages and update latches clear to 0, so scan_out is 0 and, in drive-from-latch mode, pad_out is all zeros.
- R2: When capture_en is high at a clock edge, shift stage i loads pad_in[i]. If shift_en is high in the same cycle, capture takes priority and no shift occurs.
- R3: When shift_en is high and capture_en is low at a clock edge, stage 0 loads scan_in and stage i loads stage i-1. scan_out always shows stage N-1, so a bit entered reaches scan_out after N shifts.
- R4: When update_en is high at a clock edge, latch i loads shift stage i. If a shift or capture happens in the same cycle, the latch takes the contents from before that edge.
- R5: Without update_en the update latches keep their values, so pad_out in drive-from-latch mode stays constant while shifting.
- R6: With test_drive low and iso_hiz low, pad_out equals core_out and pad_oe equals core_oe in the same cycle, with no clock involved.
- R7: With test_drive high and iso_hiz low, pad_out equals the update latches and every bit of pad_oe is 1.
- R8: With iso_hiz high, every bit of pad_oe is 0 in any mode.
- R9: With capture_en and shift_en both low, the shift stages keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial data into cell 0 |
| capture_en | input | 1 | Parallel load of the pin values into the shift stages |
| shift_en | input | 1 | Shift the chain by one cell toward scan_out |
| update_en | input | 1 | Copy the shift stages into the update latches |
| test_drive | input | 1 | Pins take values from the update latches (interconnect test / clamp) |
| iso_hiz | input | 1 | Disable all pin drivers |
| core_out | input | N | Functional output values from the core |
| core_oe | input | N | Functional output enables from the core |
| pad_in | input | N | Values observed at the pins |
| pad_out | output | N | Values driven to the pins |
| pad_oe | output | N | Pin driver enables |
| scan_out | output | 1 | Serial data from cell N-1 |

## Verification
Two pairs of operations can land in the same cycle: an update strobe together with a shift or capture, and a capture together with a shift. Directed steps raise these strobes together. Random traffic also raises them together often. A queue-based reference model in the bench judges each case: the latch must hold the pre-edge chain contents, and the captured word must win over the shift. Every clock, the bench compares pad_out, pad_oe and scan_out against the model, so a wrong ordering appears either on the pins in drive-from-latch mode or on the serial output.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan_in,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         update_en,
  input  logic         test_drive,
  input  logic         iso_hiz,
  input  logic [N-1:0] core_out,
  input  logic [N-1:0] core_oe,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic         scan_out
);

  logic [N-1:0] sh;
  logic [N-1:0] upd;

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      logic ser;
      if (i == 0) begin : g_head
        assign ser = scan_in;
      end else begin : g_link
        assign ser = sh[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sh[i] <= 1'b0;
        else if (capture_en) sh[i] <= pad_in[i];
        else if (shift_en)   sh[i] <= ser;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         upd[i] <= 1'b0;
        else if (update_en) upd[i] <= sh[i];
      end

      assign pad_out[i] = test_drive ? upd[i] : core_out[i];
      assign pad_oe[i]  = !iso_hiz && (test_drive || core_oe[i]);
    end
  endgenerate

  assign scan_out = sh[N-1];

  a_r2_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> sh == $past(pad_in));

  a_r3_shift_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture_en) |=> scan_out == $past(sh[N-2]));

  a_r4_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> upd == $past(sh));

  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(upd));

  a_r7_drive_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (test_drive && !iso_hiz) |-> (pad_out == upd && pad_oe == '1));

  a_r8_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    iso_hiz |-> pad_oe == '0);

  a_r9_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en && !shift_en) |=> $stable(sh));

endmodule

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_in = 0, capture_en = 0, shift_en = 0, update_en = 0;
  logic test_drive = 0, iso_hiz = 0;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic scan_out;

  int checks = 0;
  int fails = 0;

  bit m_sh[$];
  logic [N-1:0] m_up;

  always #10 clk = ~clk;

  bscan_chain #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .test_drive(test_drive),
    .iso_hiz(iso_hiz), .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .scan_out(scan_out)
  );

  task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] chain_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_sh[i];
    return v;
  endfunction

  task automatic step(input string req, input logic si, input logic cap, input logic sft,
                      input logic up, input logic td, input logic hz,
                      input logic [N-1:0] co, input logic [N-1:0] ce, input logic [N-1:0] pi);
    logic [N-1:0] old;
    scan_in = si; capture_en = cap; shift_en = sft; update_en = up;
    test_drive = td; iso_hiz = hz; core_out = co; core_oe = ce; pad_in = pi;
    #1;
    chk(req, "pad_out", pad_out, td ? m_up : co);
    chk(req, "pad_oe", pad_oe, hz ? '0 : (td ? '1 : ce));
    chk(req, "scan_out", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m_sh[N-1]});
    @(posedge clk);
    old = chain_vec();
    if (cap) begin
      for (int i = 0; i < N; i++) m_sh[i] = pi[i];
    end else if (sft) begin
      m_sh.push_front(si);
      void'(m_sh.pop_back());
    end
    if (up) m_up = old;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) m_sh.push_back(1'b0);
    m_up = '0;
    test_drive = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "scan_out in reset", {{(N-1){1'b0}}, scan_out}, '0);
    chk("R1", "latch in reset", pad_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: shift a known pattern through the whole chain
    for (int i = 0; i < N; i++) step("R3", (8'hB5 >> i) & 1, 0, 1, 0, 0, 0, 8'h3C, 8'hF0, 8'h00);
    for (int i = 0; i < 3; i++) step("R9", 0, 0, 0, 0, 0, 0, 8'h5A, 8'hFF, 8'h00);
    // R4 + R7: update then drive from latches
    step("R4", 0, 0, 0, 1, 1, 0, 8'h00, 8'h00, 8'h00);
    step("R7", 0, 0, 0, 0, 1, 0, 8'hFF, 8'h00, 8'h00);
    // R5: shift in test mode without update, pins must hold
    for (int i = 0; i < N; i++) step("R5", i[0], 0, 1, 0, 1, 0, 8'h00, 8'h00, 8'h00);
    // R2: capture and shift in the same cycle
    step("R2", 1, 1, 1, 0, 0, 0, 8'h11, 8'h22, 8'hC3);
    for (int i = 0; i < N; i++) step("R2", 0, 0, 1, 0, 0, 0, 8'h11, 8'h22, 8'h00);
    // R4: update together with shift takes pre-shift contents
    step("R4", 1, 1, 0, 0, 0, 0, 8'h00, 8'h00, 8'h96);
    step("R4", 1, 0, 1, 1, 1, 0, 8'h00, 8'h00, 8'h00);
    step("R4", 0, 0, 0, 0, 1, 0, 8'h00, 8'h00, 8'h00);
    // R8: isolation in both modes
    step("R8", 0, 0, 0, 0, 1, 1, 8'hFF, 8'hFF, 8'h00);
    step("R8", 0, 0, 0, 0, 0, 1, 8'hFF, 8'hFF, 8'h00);
    // R6: transparent path with varying core data
    for (int i = 0; i < 16; i++)
      step("R6", 0, 0, 0, 0, 0, 0, N'($urandom), N'($urandom), N'($urandom));

    for (int i = 0; i < 2000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step("R4", r[0], r[1] & r[2], r[3], r[4], r[5], r[6] & r[7],
           N'($urandom), N'($urandom), N'($urandom));
    end
    finish_run();
  end
endmodule